// File: doc/BRIEF.md
# Debug Output Selector with Test-Clock Bypass

This block sits beside a clock synthesizer's loop. It holds the loop's 7-bit programmable feedback counter and an eight-way selector that decides what a single-ended diagnostic pin shows. A 3-bit select code picks one of these for the pin: a constant, the serial configuration chain's shift-out bit, half the reference rate, the feedback counter's pulse train, the post-divided output, or a quarter of that output.

One select code also turns on a bypass mode. In this mode a slow external test clock drives both the feedback counter and the output post-divider in place of the oscillator clock. The diagnostic pin then shows the feedback counter, which lets a board be stepped through at low speed.

The block runs on one fabric clock. Every clock it handles arrives as a one-cycle tick strobe, one per rising edge of that clock. The post-divided output arrives as a level. The clock chosen for the post-divider leaves the block as a tick enable. When the block enters or leaves bypass, it holds both internal clock sources low for a fixed quiet window before it changes source, so no shortened pulse reaches either divider.

Top module: `tsel_unit`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `test_out` and `post_clk_en` are 0.
- R2: With `t_sel` = 3'b000 the pin shows `sro_bit`, with 3'b001 it shows 1, and with 3'b101 it shows 0. `test_out` reflects the select and data one clock cycle after they are applied.
- R3: With `t_sel` = 3'b010 the pin shows a level that inverts once for every `ref_tick`, which is the reference clock halved. The level starts at 0 after reset.
- R4: With `t_sel` = 3'b100 the pin shows `fout_lvl` delayed by one cycle. With 3'b111 it shows a level that inverts on every second rising edge of `fout_lvl`, which is the output divided by 4. That level starts at 0 after reset.
- R5: The feedback counter counts source ticks. For `m_val` of 2 or more, it emits a one-cycle pulse on every `m_val`-th source tick, and counts from zero after reset.
- R6: For `m_val` of 0 or 1, every source tick produces a feedback pulse (pass-through).
- R7: Outside bypass, `post_clk_en` repeats `pll_tick`. The feedback source is every second `pll_tick`, the second one after reset being the first. `t_sel` = 3'b011 shows the feedback pulses.
- R8: With `t_sel` = 3'b110 (bypass), `tck_tick` drives both `post_clk_en` and the feedback counter directly, and the pin shows the feedback pulses.
- R9: When bypass is entered or left, the old source stays in force for one more cycle. After that, both the post-divider enable and the feedback source stay 0 for `QUIET_CYC` cycles (default 4) before the new source takes over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle strobe per reference clock edge |
| pll_tick | input | 1 | One-cycle strobe per oscillator clock edge |
| tck_tick | input | 1 | One-cycle strobe per external test clock edge |
| m_val | input | 7 | Feedback counter modulus |
| t_sel | input | 3 | Diagnostic select code; 3'b110 is bypass |
| sro_bit | input | 1 | Serial configuration chain shift-out bit |
| fout_lvl | input | 1 | Post-divided output level |
| test_out | output | 1 | Registered diagnostic pin value |
| post_clk_en | output | 1 | Tick enable for the post-divider |

## Verification
The main path is driven with random stretches of every select code. Each stretch uses independent tick densities for the reference, oscillator and test clocks, so a source wired to the wrong clock shows up as a miscompare on both outputs. Moduli are drawn from the small range, including 0 and 1, and from the full 7-bit range. This separates the pass-through rule from ordinary wrap and exposes a counter that drops or adds a tick. Repeated entries into and exits from bypass, with tick streams that never pause, show whether the quiet window has the right length and whether the source changes only at its end. Directed pulse counts pin down the halving of the oscillator ticks and the divide-by-4 phase.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
  typedef enum logic [2:0] {
    TS_SHIFT  = 3'b000,
    TS_ONE    = 3'b001,
    TS_REF2   = 3'b010,
    TS_FB     = 3'b011,
    TS_FOUT   = 3'b100,
    TS_ZERO   = 3'b101,
    TS_BYPASS = 3'b110,
    TS_FOUT4  = 3'b111
  } tsel_e;

  typedef enum logic {
    SW_RUN   = 1'b0,
    SW_QUIET = 1'b1
  } sw_state_e;
endpackage

// File: rtl/tsel_tog_div.sv
module tsel_tog_div #(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  output logic [STAGES-1:0] q
);
  logic [STAGES-1:0] tog;

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    if (gi == 0) begin : g_first
      assign tog[gi] = tick;
    end else begin : g_next
      assign tog[gi] = tick & (&q[gi-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q ^ tog;
  end

  // R3 (and R4 through the /4 instance): the first stage inverts on every tick
  p_low_stage_toggles_r3: assert property (@(posedge clk) disable iff (rst)
    tick |=> (q[0] != $past(q[0])));
  p_hold_without_tick_r3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(q));
endmodule

// File: rtl/tsel_clk_switch.sv
module tsel_clk_switch
  import tsel_pkg::*;
#(
  parameter int QUIET_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic byp_req,
  input  logic pll_tick,
  input  logic tck_tick,
  output logic div_tick,
  output logic fb_src,
  output logic byp_act
);
  localparam int QW = (QUIET_CYC < 2) ? 1 : $clog2(QUIET_CYC + 1);
  localparam logic [QW-1:0] QLAST = QW'(QUIET_CYC - 1);

  sw_state_e     st_q;
  logic [QW-1:0] qcnt_q;
  logic          half_q;
  logic          run;

  assign run = (st_q == SW_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SW_RUN;
      qcnt_q  <= '0;
      byp_act <= 1'b0;
    end else if (st_q == SW_RUN) begin
      if (byp_req != byp_act) begin
        st_q   <= SW_QUIET;
        qcnt_q <= '0;
      end
    end else if (qcnt_q == QLAST) begin
      st_q    <= SW_RUN;
      byp_act <= byp_req;
    end else begin
      qcnt_q <= qcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q   <= 1'b0;
      div_tick <= 1'b0;
      fb_src   <= 1'b0;
    end else begin
      if (pll_tick) half_q <= ~half_q;
      div_tick <= run & (byp_act ? tck_tick : pll_tick);
      fb_src   <= run & (byp_act ? tck_tick : (pll_tick & half_q));
    end
  end

  p_quiet_silent_r9: assert property (@(posedge clk) disable iff (rst)
    (st_q == SW_QUIET) |=> (!div_tick && !fb_src));
  p_change_after_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(byp_act) |-> $past(st_q == SW_QUIET));
  p_normal_halving_r7: assert property (@(posedge clk) disable iff (rst)
    fb_src && !byp_act |-> $past(pll_tick));
endmodule

// File: rtl/tsel_fb_counter.sv
module tsel_fb_counter #(
  parameter int MW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          src_tick,
  input  logic [MW-1:0] m_val,
  output logic          fb_pulse
);
  logic [MW-1:0] cnt_q;
  logic          thru;

  assign thru = (m_val <= MW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      fb_pulse <= 1'b0;
    end else begin
      fb_pulse <= 1'b0;
      if (src_tick) begin
        if (thru || cnt_q >= m_val - 1'b1) begin
          cnt_q    <= '0;
          fb_pulse <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  p_pass_through_r6: assert property (@(posedge clk) disable iff (rst)
    (src_tick && thru) |=> fb_pulse);
  p_no_pulse_without_src_r5: assert property (@(posedge clk) disable iff (rst)
    !src_tick |=> !fb_pulse);
  p_pulse_restarts_r5: assert property (@(posedge clk) disable iff (rst)
    fb_pulse |-> (cnt_q == '0));
endmodule

// File: rtl/tsel_unit.sv
module tsel_unit
  import tsel_pkg::*;
#(
  parameter int MW        = 7,
  parameter int QUIET_CYC = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_tick,
  input  logic          pll_tick,
  input  logic          tck_tick,
  input  logic [MW-1:0] m_val,
  input  logic [2:0]    t_sel,
  input  logic          sro_bit,
  input  logic          fout_lvl,
  output logic          test_out,
  output logic          post_clk_en
);
  logic       byp_req, byp_act, fb_src, fb_pulse;
  logic       fout_prev, fout_rise;
  logic [0:0] ref_q;
  logic [1:0] fout_q;

  assign byp_req   = (t_sel == TS_BYPASS);
  assign fout_rise = fout_lvl & ~fout_prev;

  tsel_clk_switch #(.QUIET_CYC(QUIET_CYC)) u_switch (
    .clk(clk), .rst(rst), .byp_req(byp_req), .pll_tick(pll_tick),
    .tck_tick(tck_tick), .div_tick(post_clk_en), .fb_src(fb_src),
    .byp_act(byp_act)
  );

  tsel_fb_counter #(.MW(MW)) u_fb (
    .clk(clk), .rst(rst), .src_tick(fb_src), .m_val(m_val), .fb_pulse(fb_pulse)
  );

  tsel_tog_div #(.STAGES(1)) u_ref_half (
    .clk(clk), .rst(rst), .tick(ref_tick), .q(ref_q)
  );

  tsel_tog_div #(.STAGES(2)) u_fout_quarter (
    .clk(clk), .rst(rst), .tick(fout_rise), .q(fout_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fout_prev <= 1'b0;
      test_out  <= 1'b0;
    end else begin
      fout_prev <= fout_lvl;
      case (tsel_e'(t_sel))
        TS_SHIFT:  test_out <= sro_bit;
        TS_ONE:    test_out <= 1'b1;
        TS_REF2:   test_out <= ref_q[0];
        TS_FB:     test_out <= fb_pulse;
        TS_FOUT:   test_out <= fout_lvl;
        TS_ZERO:   test_out <= 1'b0;
        TS_BYPASS: test_out <= fb_pulse;
        default:   test_out <= fout_q[1];
      endcase
    end
  end

  p_const_one_r2: assert property (@(posedge clk) disable iff (rst)
    (t_sel == TS_ONE) |=> test_out);
  p_const_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (t_sel == TS_ZERO) |=> !test_out);
  p_bypass_enable_r8: assert property (@(posedge clk) disable iff (rst)
    (post_clk_en && byp_act) |-> $past(tck_tick));
endmodule

// File: tb/tsel_unit_test.sv
module tsel_unit_test;
  localparam int QC = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_tick = 0, pll_tick = 0, tck_tick = 0, sro_bit = 0, fout_lvl = 0;
  logic [6:0] m_val = 7'd0;
  logic [2:0] t_sel = 3'b000;
  logic       test_out, post_clk_en;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  tsel_unit #(.MW(7), .QUIET_CYC(QC)) uut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .pll_tick(pll_tick),
    .tck_tick(tck_tick), .m_val(m_val), .t_sel(t_sel), .sro_bit(sro_bit),
    .fout_lvl(fout_lvl), .test_out(test_out), .post_clk_en(post_clk_en)
  );

  // expected-state model
  bit e_quiet, e_byp, e_half, e_div, e_src, e_pulse, e_refh, e_fprev, e_test;
  bit [1:0] e_fq;
  int e_qcnt, e_cnt;
  string tag_div, tag_test;

  task automatic model_reset();
    e_quiet = 0; e_byp = 0; e_half = 0; e_div = 0; e_src = 0; e_pulse = 0;
    e_refh = 0; e_fprev = 0; e_test = 0; e_fq = 0; e_qcnt = 0; e_cnt = 0;
  endtask

  function automatic string test_tag(input bit [2:0] t, input int m);
    case (t)
      3'b010:         return "R3";
      3'b100, 3'b111: return "R4";
      3'b011:         return (m <= 1) ? "R6" : "R5";
      3'b110:         return "R8";
      default:        return "R2";
    endcase
  endfunction

  task automatic model_step();
    bit n_div, n_src, n_pulse, n_test, rise;
    int m = int'(m_val);
    tag_div  = e_quiet ? "R9" : (e_byp ? "R8" : "R7");
    tag_test = test_tag(t_sel, m);
    n_div = !e_quiet && (e_byp ? tck_tick : pll_tick);
    n_src = !e_quiet && (e_byp ? tck_tick : (pll_tick && e_half));
    n_pulse = 0;
    if (e_src) begin
      if (m <= 1 || e_cnt >= m - 1) begin e_cnt = 0; n_pulse = 1; end
      else e_cnt++;
    end
    case (t_sel)
      3'b000: n_test = sro_bit;
      3'b001: n_test = 1;
      3'b010: n_test = e_refh;
      3'b011, 3'b110: n_test = e_pulse;
      3'b100: n_test = fout_lvl;
      3'b101: n_test = 0;
      default: n_test = e_fq[1];
    endcase
    if (!e_quiet) begin
      if ((t_sel == 3'b110) != e_byp) begin e_quiet = 1; e_qcnt = 0; end
    end else if (e_qcnt == QC - 1) begin
      e_quiet = 0; e_byp = (t_sel == 3'b110);
    end else e_qcnt++;
    if (pll_tick) e_half = !e_half;
    if (ref_tick) e_refh = !e_refh;
    rise = fout_lvl && !e_fprev;
    e_fprev = fout_lvl;
    if (rise) begin
      if (e_fq[0]) e_fq[1] = !e_fq[1];
      e_fq[0] = !e_fq[0];
    end
    e_div = n_div; e_src = n_src; e_pulse = n_pulse; e_test = n_test;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: inputs already set at the falling edge
  task automatic cycle();
    @(posedge clk); #1;
    model_step();
    chk(tag_test, int'(test_out), int'(e_test));
    chk(tag_div, int'(post_clk_en), int'(e_div));
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    ref_tick = 0; pll_tick = 0; tck_tick = 0; fout_lvl = 0; sro_bit = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; idle_inputs(); t_sel = 3'b000;
    repeat (2) @(negedge clk);
    model_reset();
    chk("R1", int'(test_out), 0);
    chk("R1", int'(post_clk_en), 0);
    rst = 0;
  endtask

  int hits;

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    cycle();
    chk("R1", int'(test_out), 0);

    // R5: modulus 5, a pll tick every cycle -> 20 feedback source ticks -> 4 pulses
    do_reset(); t_sel = 3'b011; m_val = 7'd5; pll_tick = 1; hits = 0;
    for (int i = 0; i < 40; i++) begin cycle(); hits += int'(test_out); end
    pll_tick = 0;
    for (int i = 0; i < 4; i++) begin cycle(); hits += int'(test_out); end
    chk("R5", hits, 4);

    // R6: modulus 0 passes every source tick; R7 halving gives 10 of 20
    do_reset(); t_sel = 3'b011; m_val = 7'd0; pll_tick = 1; hits = 0;
    for (int i = 0; i < 20; i++) begin cycle(); hits += int'(test_out); end
    pll_tick = 0;
    for (int i = 0; i < 4; i++) begin cycle(); hits += int'(test_out); end
    chk("R6", hits, 10);

    // R9 / R8: enter bypass with a continuous test clock
    do_reset(); t_sel = 3'b110; m_val = 7'd3; tck_tick = 1; hits = 0;
    for (int i = 0; i < QC + 1; i++) begin cycle(); hits += int'(post_clk_en); end
    chk("R9", hits, 0);
    hits = 0;
    for (int i = 0; i < 30; i++) begin cycle(); hits += int'(post_clk_en); end
    chk("R8", hits, 30);
    // leave bypass: one more test tick, then a silent window
    t_sel = 3'b011;
    cycle(); chk("R9", int'(post_clk_en), 1);
    hits = 0;
    for (int i = 0; i < QC; i++) begin cycle(); hits += int'(post_clk_en); end
    chk("R9", hits, 0);
    tck_tick = 0;

    // R8: bypass feedback pulses with modulus 3 over 30 test ticks
    do_reset(); t_sel = 3'b110; m_val = 7'd3; tck_tick = 1; hits = 0;
    for (int i = 0; i < QC + 31; i++) begin cycle(); hits += int'(test_out); end
    tck_tick = 0;
    for (int i = 0; i < 4; i++) begin cycle(); hits += int'(test_out); end
    chk("R8", hits, 10);

    // R3: one reference tick sets the halved level
    do_reset(); t_sel = 3'b010; ref_tick = 1; cycle(); ref_tick = 0; cycle();
    chk("R3", int'(test_out), 1);

    // R4: two rising output edges set the quarter level
    do_reset(); t_sel = 3'b111;
    fout_lvl = 1; cycle(); fout_lvl = 0; cycle(); fout_lvl = 1; cycle(); fout_lvl = 0; cycle();
    chk("R4", int'(test_out), 1);

    // R2: constants and shift-out
    t_sel = 3'b001; cycle(); chk("R2", int'(test_out), 1);
    t_sel = 3'b101; cycle(); chk("R2", int'(test_out), 0);
    t_sel = 3'b000; sro_bit = 1; cycle(); chk("R2", int'(test_out), 1);

    // random stretches across every select code
    do_reset();
    for (int s = 0; s < 400; s++) begin
      int len = $urandom_range(60, 10);
      int pd  = $urandom_range(100, 10);
      t_sel = 3'($urandom_range(7, 0));
      m_val = ($urandom_range(1, 0) == 1) ? 7'($urandom_range(9, 0))
                                          : 7'($urandom_range(127, 0));
      for (int c = 0; c < len; c++) begin
        ref_tick = ($urandom_range(99, 0) < 50);
        pll_tick = ($urandom_range(99, 0) < pd);
        tck_tick = ($urandom_range(99, 0) < 40);
        sro_bit  = $urandom_range(1, 0) == 1;
        if ($urandom_range(99, 0) < 30) fout_lvl = !fout_lvl;
        cycle();
      end
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vectors++; misses++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule